// File: doc/BRIEF.md
# Nibble-Memory Return Stack Controller

This block carries out subroutine calls and returns for a 4-bit processor that keeps its return stack in the ordinary nibble-wide data memory instead of in a dedicated register file. When the decoder signals a call, the block stores the 12-bit return address as three nibbles in a reserved region of data memory. It then advances a 3-bit stack pointer and hands the call target to the program counter.

When the decoder signals a return, the block first moves the pointer back. It then reads the three nibbles on consecutive cycles and rebuilds the program counter. In the same cycle it writes the 4-bit immediate carried by the return instruction into register R0. Because each return also loads R0, a table built from return instructions can be read one entry per call.

The processor stalls while `busy` is high. The block owns the data-memory port for the length of an operation. Its completion is signalled by a one-cycle `done` pulse, which comes with `pc_load`.

Top module: `nib_ret_stack`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `mem_we`, `mem_re`, `pc_load` and `r0_we` are low, and the stack pointer is 0, so the next call writes at address 0x10.
- R2: The call accepted at clock edge E1 makes `mem_we` high in the three cycles after edges E1, E2 and E3. It writes return-address bits [3:0], [7:4] and [11:8], in that order, to addresses B, B+1 and B+2. Here B = 0x10 + 3 × SP.
- R3: In the cycle after E4 of a call, `pc_load` and `done` are high for one cycle with `pc_value` equal to the call target. `busy` is high in the three write cycles and low in that cycle.
- R4: The stack pointer increments by one after a push completes. The next call writes at the following base address.
- R5: A return accepted at E1 first decrements the pointer. It then holds `mem_re` high with addresses B, B+1 and B+2 in the cycles after E1, E2 and E3, where B uses the decremented pointer. The memory returns `mem_rdata` one cycle after it samples an address with `mem_re` high.
- R6: In the cycle after E5 of a return, `pc_load`, `done` and `r0_we` are high together for one cycle. `pc_value` is the three nibbles read, with the first read as the low nibble, and `r0_data` is the return immediate. `busy` is high from the cycle after E1 through the cycle after E4.
- R7: The pointer wraps modulo 8 in both directions. A ninth nested call writes at 0x10 again, and a return at pointer 0 reads from 0x25.
- R8: `call_req` and `ret_req` are ignored while an operation is in progress. They change neither the memory accesses nor the pointer.
- R9: When `call_req` and `ret_req` are high in the same idle cycle, the call is performed and the return is dropped.
- R10: Memory accesses stay inside the stack region 0x10 to 0x27, and a write and a read are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Call strobe from the decoder |
| call_ret_pc | input | 12 | Return address (address of the next instruction) |
| call_target | input | 12 | Call destination |
| ret_req | input | 1 | Return strobe from the decoder |
| ret_imm | input | 4 | Immediate carried by the return instruction |
| mem_addr | output | 8 | Data-memory address |
| mem_we | output | 1 | Data-memory write enable |
| mem_re | output | 1 | Data-memory read enable |
| mem_wdata | output | 4 | Data-memory write nibble |
| mem_rdata | input | 4 | Data-memory read nibble, one cycle after the address |
| busy | output | 1 | Operation in progress; requests ignored |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | Load `pc_value` into the program counter |
| pc_value | output | 12 | Call target or restored return address |
| r0_we | output | 1 | Write strobe for register R0 |
| r0_data | output | 4 | Value for R0 |

## Verification
A corrupt stack pointer shows up at the ports in the first cycle after a request is accepted, because the first address on `mem_addr` is off by a multiple of three. A skipped or doubled pointer update shows up on the next operation. An error in nibble order or in read-data alignment stays hidden until the end of a return. It then shows as a wrong `pc_value`, five cycles after the return was accepted. A request that leaks through while busy disturbs the address sequence or the pointer. That is visible at the following operation at the latest.

// File: rtl/nib_ret_stack_pkg.sv
package nib_ret_stack_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_PUSH = 2'd1,
    RS_POP  = 2'd2
  } rs_state_e;
endpackage

// File: rtl/nib_ret_stack_ptr.sv
module nib_ret_stack_ptr #(
  parameter int DEPTH = 8,
  parameter int SP_W  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            dec,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_prev
);
  localparam logic [SP_W-1:0] TOP = SP_W'(DEPTH - 1);
  localparam logic [SP_W-1:0] ONE = SP_W'(1);

  generate
    if ((1 << SP_W) == DEPTH) begin : g_pow2
      always_comb sp_prev = sp - ONE;
      always_ff @(posedge clk) begin
        if (rst)      sp <= '0;
        else if (inc) sp <= sp + ONE;
        else if (dec) sp <= sp - ONE;
      end
    end else begin : g_mod
      always_comb sp_prev = (sp == '0) ? TOP : sp - ONE;
      always_ff @(posedge clk) begin
        if (rst)      sp <= '0;
        else if (inc) sp <= (sp == TOP) ? '0 : sp + ONE;
        else if (dec) sp <= sp_prev;
      end
    end
  endgenerate
endmodule

// File: rtl/nib_ret_stack_addr.sv
module nib_ret_stack_addr #(
  parameter int MEM_AW    = 8,
  parameter int SP_W      = 3,
  parameter int OFF_W     = 2,
  parameter int PAGE_BASE = 16,
  parameter int NIBS      = 3
) (
  input  logic [SP_W-1:0]   sp,
  input  logic [OFF_W-1:0]  off,
  output logic [MEM_AW-1:0] addr
);
  localparam logic [MEM_AW-1:0] BASE   = MEM_AW'(PAGE_BASE);
  localparam logic [MEM_AW-1:0] STRIDE = MEM_AW'(NIBS);

  always_comb addr = BASE + MEM_AW'(sp) * STRIDE + MEM_AW'(off);
endmodule

// File: rtl/nib_ret_stack_seq.sv
module nib_ret_stack_seq
  import nib_ret_stack_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int NIB_W  = 4,
  parameter int MEM_AW = 8,
  parameter int SP_W   = 3,
  parameter int NIBS   = PC_W / NIB_W,
  parameter int STEP_W = $clog2(NIBS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_req,
  input  logic [PC_W-1:0]   call_ret_pc,
  input  logic [PC_W-1:0]   call_target,
  input  logic              ret_req,
  input  logic [NIB_W-1:0]  ret_imm,
  input  logic [NIB_W-1:0]  mem_rdata,
  input  logic [MEM_AW-1:0] addr_in,
  input  logic [SP_W-1:0]   sp,
  input  logic [SP_W-1:0]   sp_prev,
  output logic [SP_W-1:0]   addr_sp,
  output logic [STEP_W-1:0] addr_off,
  output logic              sp_inc,
  output logic              sp_dec,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [NIB_W-1:0]  mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_value,
  output logic              r0_we,
  output logic [NIB_W-1:0]  r0_data
);
  localparam logic [STEP_W-1:0] LAST_NIB = STEP_W'(NIBS - 1);
  localparam logic [STEP_W-1:0] POP_END  = STEP_W'(NIBS);
  localparam logic [STEP_W-1:0] ONE      = STEP_W'(1);

  rs_state_e         state;
  logic [STEP_W-1:0] step;
  logic [PC_W-1:0]   ret_q;
  logic [PC_W-1:0]   tgt_q;
  logic [PC_W-1:0]   acc_q;
  logic [NIB_W-1:0]  imm_q;
  logic              take_call;
  logic              take_ret;

  always_comb begin
    take_call = (state == RS_IDLE) && call_req;
    take_ret  = (state == RS_IDLE) && !call_req && ret_req;
    sp_dec    = take_ret;
    sp_inc    = (state == RS_PUSH) && (step == LAST_NIB);
    addr_sp   = take_ret ? sp_prev : sp;
    addr_off  = (state == RS_IDLE) ? '0 : step + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RS_IDLE;
      step      <= '0;
      ret_q     <= '0;
      tgt_q     <= '0;
      acc_q     <= '0;
      imm_q     <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      pc_load   <= 1'b0;
      pc_value  <= '0;
      r0_we     <= 1'b0;
      r0_data   <= '0;
    end else begin
      done    <= 1'b0;
      pc_load <= 1'b0;
      r0_we   <= 1'b0;
      unique case (state)
        RS_IDLE: begin
          step <= '0;
          if (take_call) begin
            state     <= RS_PUSH;
            busy      <= 1'b1;
            tgt_q     <= call_target;
            ret_q     <= call_ret_pc >> NIB_W;
            mem_we    <= 1'b1;
            mem_addr  <= addr_in;
            mem_wdata <= call_ret_pc[NIB_W-1:0];
          end else if (take_ret) begin
            state    <= RS_POP;
            busy     <= 1'b1;
            imm_q    <= ret_imm;
            mem_re   <= 1'b1;
            mem_addr <= addr_in;
          end
        end
        RS_PUSH: begin
          if (step == LAST_NIB) begin
            state    <= RS_IDLE;
            step     <= '0;
            busy     <= 1'b0;
            mem_we   <= 1'b0;
            done     <= 1'b1;
            pc_load  <= 1'b1;
            pc_value <= tgt_q;
          end else begin
            step      <= step + ONE;
            mem_addr  <= addr_in;
            mem_wdata <= ret_q[NIB_W-1:0];
            ret_q     <= ret_q >> NIB_W;
          end
        end
        RS_POP: begin
          if (step != '0) acc_q <= {mem_rdata, acc_q[PC_W-1:NIB_W]};
          if (step == POP_END) begin
            state    <= RS_IDLE;
            step     <= '0;
            busy     <= 1'b0;
            done     <= 1'b1;
            pc_load  <= 1'b1;
            pc_value <= {mem_rdata, acc_q[PC_W-1:NIB_W]};
            r0_we    <= 1'b1;
            r0_data  <= imm_q;
          end else begin
            step <= step + ONE;
            if (step < LAST_NIB) mem_addr <= addr_in;
            else                 mem_re   <= 1'b0;
          end
        end
        default: begin
          state  <= RS_IDLE;
          busy   <= 1'b0;
          mem_we <= 1'b0;
          mem_re <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/nib_ret_stack.sv
module nib_ret_stack #(
  parameter int PC_W      = 12,
  parameter int NIB_W     = 4,
  parameter int MEM_AW    = 8,
  parameter int DEPTH     = 8,
  parameter int PAGE_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_req,
  input  logic [PC_W-1:0]   call_ret_pc,
  input  logic [PC_W-1:0]   call_target,
  input  logic              ret_req,
  input  logic [NIB_W-1:0]  ret_imm,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [NIB_W-1:0]  mem_wdata,
  input  logic [NIB_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_value,
  output logic              r0_we,
  output logic [NIB_W-1:0]  r0_data
);
  localparam int SP_W   = $clog2(DEPTH);
  localparam int NIBS   = PC_W / NIB_W;
  localparam int STEP_W = $clog2(NIBS + 1);

  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   sp_prev;
  logic [SP_W-1:0]   addr_sp;
  logic [STEP_W-1:0] addr_off;
  logic [MEM_AW-1:0] addr_in;
  logic              sp_inc;
  logic              sp_dec;

  nib_ret_stack_ptr #(.DEPTH(DEPTH), .SP_W(SP_W)) u_ptr (
    .clk(clk), .rst(rst), .inc(sp_inc), .dec(sp_dec),
    .sp(sp), .sp_prev(sp_prev)
  );

  nib_ret_stack_addr #(
    .MEM_AW(MEM_AW), .SP_W(SP_W), .OFF_W(STEP_W),
    .PAGE_BASE(PAGE_BASE), .NIBS(NIBS)
  ) u_addr (
    .sp(addr_sp), .off(addr_off), .addr(addr_in)
  );

  nib_ret_stack_seq #(
    .PC_W(PC_W), .NIB_W(NIB_W), .MEM_AW(MEM_AW),
    .SP_W(SP_W), .NIBS(NIBS), .STEP_W(STEP_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .call_req(call_req), .call_ret_pc(call_ret_pc), .call_target(call_target),
    .ret_req(ret_req), .ret_imm(ret_imm), .mem_rdata(mem_rdata),
    .addr_in(addr_in), .sp(sp), .sp_prev(sp_prev),
    .addr_sp(addr_sp), .addr_off(addr_off),
    .sp_inc(sp_inc), .sp_dec(sp_dec),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .pc_load(pc_load), .pc_value(pc_value),
    .r0_we(r0_we), .r0_data(r0_data)
  );
endmodule

// File: rtl/nib_ret_stack_chk.sv
module nib_ret_stack_chk #(
  parameter int PC_W      = 12,
  parameter int NIB_W     = 4,
  parameter int MEM_AW    = 8,
  parameter int DEPTH     = 8,
  parameter int PAGE_BASE = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              call_req,
  input logic [PC_W-1:0]   call_ret_pc,
  input logic [PC_W-1:0]   call_target,
  input logic              ret_req,
  input logic [NIB_W-1:0]  ret_imm,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [NIB_W-1:0]  mem_wdata,
  input logic [NIB_W-1:0]  mem_rdata,
  input logic              busy,
  input logic              done,
  input logic              pc_load,
  input logic [PC_W-1:0]   pc_value,
  input logic              r0_we,
  input logic [NIB_W-1:0]  r0_data
);
  localparam logic [MEM_AW-1:0] LO  = MEM_AW'(PAGE_BASE);
  localparam logic [MEM_AW-1:0] HI  = MEM_AW'(PAGE_BASE + DEPTH * (PC_W / NIB_W) - 1);
  localparam logic [MEM_AW-1:0] ONE = MEM_AW'(1);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_we && !mem_re && !pc_load && !r0_we));

  a_r2_write_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ONE));

  a_r5_read_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + ONE));

  a_r3_load_with_done: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (done && !busy));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_r0_with_load: assert property (@(posedge clk) disable iff (rst)
    r0_we |-> pc_load);

  a_r10_in_region: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> (mem_addr >= LO && mem_addr <= HI));

  a_r10_no_we_re: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  a_r8_access_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy);
endmodule

bind nib_ret_stack nib_ret_stack_chk #(
  .PC_W(PC_W), .NIB_W(NIB_W), .MEM_AW(MEM_AW),
  .DEPTH(DEPTH), .PAGE_BASE(PAGE_BASE)
) u_chk (.*);

// File: tb/nib_ret_stack_test.sv
module nib_ret_stack_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_req = 1'b0;
  logic [11:0] call_ret_pc = '0;
  logic [11:0] call_target = '0;
  logic        ret_req = 1'b0;
  logic [3:0]  ret_imm = '0;
  logic [7:0]  mem_addr;
  logic        mem_we, mem_re;
  logic [3:0]  mem_wdata;
  logic [3:0]  mem_rdata = '0;
  logic        busy, done, pc_load, r0_we;
  logic [11:0] pc_value;
  logic [3:0]  r0_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit noise = 1'b0;
  int sp_m = 0;
  logic [11:0] shadow [8];
  logic [3:0]  mem [256];

  always #2 clk = ~clk;

  nib_ret_stack uut (
    .clk(clk), .rst(rst), .call_req(call_req), .call_ret_pc(call_ret_pc),
    .call_target(call_target), .ret_req(ret_req), .ret_imm(ret_imm),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_load(pc_load),
    .pc_value(pc_value), .r0_we(r0_we), .r0_data(r0_data)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [7:0] base_of(int sp);
    return 8'(16 + 3 * sp);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic poke_noise(bit on);
    if (on && noise) begin
      call_req    = 1'($urandom);
      ret_req     = 1'($urandom);
      call_ret_pc = 12'($urandom);
      call_target = 12'($urandom);
      ret_imm     = 4'($urandom);
    end else begin
      call_req = 1'b0;
      ret_req  = 1'b0;
    end
  endtask

  task automatic do_call(logic [11:0] rpc, logic [11:0] tgt, bit with_ret);
    logic [7:0] b;
    b = base_of(sp_m);
    call_ret_pc = rpc; call_target = tgt; call_req = 1'b1; ret_req = with_ret;
    ret_imm = 4'hA;
    @(posedge clk); @(negedge clk);
    poke_noise(1'b0);
    for (int n = 1; n <= 3; n++) begin
      chk("R2 we", {31'd0, mem_we}, 32'd1);
      chk("R2 addr", {24'd0, mem_addr}, {24'd0, b + 8'(n - 1)});
      chk("R2 data", {28'd0, mem_wdata}, {28'd0, rpc[4*(n-1) +: 4]});
      chk("R3 busy", {31'd0, busy}, 32'd1);
      chk("R9 no read", {31'd0, mem_re}, 32'd0);
      poke_noise(1'b1);
      @(negedge clk);
    end
    poke_noise(1'b0);
    chk("R3 load", {31'd0, pc_load}, 32'd1);
    chk("R3 target", {20'd0, pc_value}, {20'd0, tgt});
    chk("R3 done", {31'd0, done}, 32'd1);
    chk("R3 idle", {30'd0, busy, mem_we}, 32'd0);
    chk("R3 no r0", {31'd0, r0_we}, 32'd0);
    shadow[sp_m] = rpc;
    sp_m = (sp_m + 1) % 8;
  endtask

  task automatic do_ret(logic [3:0] imm);
    logic [7:0] b;
    sp_m = (sp_m + 7) % 8;
    b = base_of(sp_m);
    ret_imm = imm; ret_req = 1'b1; call_req = 1'b0;
    @(posedge clk); @(negedge clk);
    poke_noise(1'b0);
    for (int n = 1; n <= 4; n++) begin
      chk("R6 busy", {31'd0, busy}, 32'd1);
      chk("R6 no load", {31'd0, pc_load}, 32'd0);
      chk("R5 re", {31'd0, mem_re}, (n <= 3) ? 32'd1 : 32'd0);
      if (n <= 3) chk("R5 addr", {24'd0, mem_addr}, {24'd0, b + 8'(n - 1)});
      chk("R10 no we", {31'd0, mem_we}, 32'd0);
      poke_noise(1'b1);
      @(negedge clk);
    end
    poke_noise(1'b0);
    chk("R6 load", {31'd0, pc_load}, 32'd1);
    chk("R6 pc", {20'd0, pc_value}, {20'd0, shadow[sp_m]});
    chk("R6 r0 we", {31'd0, r0_we}, 32'd1);
    chk("R6 r0 data", {28'd0, r0_data}, {28'd0, imm});
    chk("R6 done idle", {30'd0, done, busy}, 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs", {26'd0, busy, done, mem_we, mem_re, pc_load, r0_we}, 32'd0);
    // R9: both strobes together, call wins; R1: first base is 0x10
    do_call(12'h3C5, 12'h7E1, 1'b1);
    do_ret(4'h9);
    // R7: return at pointer 0 reads from 0x25
    do_ret(4'h2);
    do_call(12'h111, 12'h222, 1'b0);
    // R4/R7: nine nested calls, the ninth wraps to 0x10
    for (int i = 0; i < 9; i++) do_call(12'(12'h100 * i + 12'h0AB), 12'(i), 1'b0);
    for (int i = 0; i < 9; i++) do_ret(4'(i));
    // R8: requests while busy are noise; random mix afterwards
    noise = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(1, 0) == 1)
        do_call(12'($urandom), 12'($urandom), 1'($urandom));
      else
        do_ret(4'($urandom));
      repeat ($urandom_range(2, 0)) @(negedge clk);
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule